// File: doc/BRIEF.md
# Synchronous Clock Stop and Power-Down Controller

This block sits between a set of free-running source clocks and the pins that distribute them. It gates eight clock groups (CPU, CPU-half, APIC, 66 MHz, stoppable PCI, free-running PCI, REF and 48 MHz) under three active-low requests: one that stops the CPU-side clocks, one that stops the stoppable PCI clock, and one that powers the whole device down. Every request is brought into the free-running PCI source domain through a synchronizer. Each group's enable is then re-registered on the falling edge of that group's own source. A clock can therefore only start or stop while it is low, so every high pulse it produces is full width.

Leaving power-down turns the oscillator enable back on at once. The clocks stay quiet until a power-up delay, counted in free-running PCI edges, has expired. The default count is about 3 ms at 33 MHz, and a bench can make it short. Reset holds all outputs low and re-arms that delay.

Top module: `clkstop_ctrl`

## Requirements
- R1: While the synchronized power-down request is low (`pwr_dn_n` sampled low on two successive rising edges of `clk_src[5]`), every bit of `clk_out` is held low from that bit's next falling source edge onward, and `osc_en` is low.
- R2: A low `cpu_stop_n`, once synchronized, holds `clk_out[0]` (CPU) and `clk_out[3]` (66 MHz) low from their next falling source edge. A high `cpu_stop_n` releases them the same way.
- R3: A low `pci_stop_n`, once synchronized, holds `clk_out[4]` (stoppable PCI) low, while `clk_out[5]` (free-running PCI) keeps following its source.
- R4: `clk_out[1]` (CPU-half), `clk_out[2]` (APIC), `clk_out[6]` (REF) and `clk_out[7]` (48 MHz) follow their sources whenever the device is powered and the delay has expired, whatever the values of `cpu_stop_n` and `pci_stop_n`.
- R5: After power-down is released, `osc_en` rises as soon as the release is synchronized. No clock output runs until `PWRUP_CYC` rising edges of `clk_src[5]` have seen the synchronized release.
- R6: A synchronous active-high `rst` drives all outputs and `osc_en` low and re-arms the power-up delay, so after reset the clocks return only after the full delay.
- R7: A gated output never rises except together with its source's rising edge, and it is never high while its source is low (no runt pulses).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen in every clock domain |
| clk_src | input | 8 | Source clocks: 0 CPU, 1 CPU-half, 2 APIC, 3 66 MHz, 4 PCI, 5 free-running PCI (reference), 6 REF, 7 48 MHz |
| cpu_stop_n | input | 1 | Active-low request to stop the CPU and 66 MHz groups |
| pci_stop_n | input | 1 | Active-low request to stop the stoppable PCI group |
| pwr_dn_n | input | 1 | Active-low power-down request |
| clk_out | output | 8 | Gated clocks, same bit order as `clk_src` |
| osc_en | output | 1 | Oscillator/VCO enable, high when not powered down |

## Verification
The bench drives eight clocks with unrelated half-periods. Many of their falling edges coincide with a reference rising edge, so a design that let an enable change on the same edge as its synchronizer update would be off by one edge on those groups. Power-down is released and then reasserted before the delay expires. A reset is applied while the clocks run, and CPU-stop is held through a whole power cycle. A counter that did not restart, or a stop that did not survive power-up, would bring clocks back too early or on the wrong groups. One CPU-stop pulse is shorter than a reference period, and the per-edge model decides whether the synchronizer catches it. Any gate that was not aligned to the falling edge would show up as an output rising without its source.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Number of gated clock groups; bit positions below are the port order.
    localparam int NGRP = 8;

    typedef enum int unsigned {
        G_CPU  = 0,
        G_CPUH = 1,
        G_APIC = 2,
        G_M66  = 3,
        G_PCI  = 4,
        G_PCIF = 5,
        G_REF  = 6,
        G_U48  = 7
    } grp_e;

    // Synchronized control levels: 1 means "allowed to run".
    typedef struct packed {
        logic pwr_ok;
        logic pci_run;
        logic cpu_run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Which stop requests can reach a group (power-down reaches all).
    typedef struct packed {
        logic by_cpu;
        logic by_pci;
    } reach_t;

    function automatic reach_t reach_of(int unsigned g);
        reach_t r;
        r.by_cpu = (g == G_CPU) || (g == G_M66);
        r.by_pci = (g == G_PCI);
        return r;
    endfunction

    function automatic logic group_allowed(reach_t r, ctl_t c, logic run_ok);
        logic ok;
        ok = run_ok & c.pwr_ok;
        if (r.by_cpu) ok = ok & c.cpu_run;
        if (r.by_pci) ok = ok & c.pci_run;
        return ok;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
// Multi-stage level synchronizer into the reference domain.
module clkstop_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/clkstop_pwrup.sv
// Power-up delay: counts reference edges that see the synchronized release.
module clkstop_pwrup #(
    parameter int PWRUP_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    output logic run_ok
);

    localparam int CW = $clog2(PWRUP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRUP_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) begin
            cnt    <= '0;
            run_ok <= 1'b0;
        end else if (!run_ok) begin
            if (cnt == LAST) run_ok <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/clkstop_enables.sv
// Per-group enable requests in the reference domain.
module clkstop_enables
    import clkstop_pkg::*;
(
    input  ctl_t            ctl,
    input  logic            run_ok,
    output logic [NGRP-1:0] en_req
);

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_en
            localparam reach_t RCH = reach_of(g);
            always_comb en_req[g] = group_allowed(RCH, ctl, run_ok);
        end
    endgenerate

endmodule

// File: rtl/clkstop_gate.sv
// Glitch-free gate: enable captured while the source is low.
module clkstop_gate (
    input  logic src,
    input  logic rst,
    input  logic en_in,
    output logic gclk
);

    logic en_q;

    always_ff @(negedge src) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_in;
    end

    assign gclk = src & en_q;

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int PWRUP_CYC   = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic            rst,
    input  logic [NGRP-1:0] clk_src,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pwr_dn_n,
    output logic [NGRP-1:0] clk_out,
    output logic            osc_en
);

    logic            ref_clk;
    ctl_t            ctl_raw;
    ctl_t            ctl_s;
    logic            run_ok;
    logic [NGRP-1:0] en_req;

    assign ref_clk = clk_src[G_PCIF];

    always_comb begin
        ctl_raw.pwr_ok  = pwr_dn_n;
        ctl_raw.pci_run = pci_stop_n;
        ctl_raw.cpu_run = cpu_stop_n;
    end

    clkstop_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (ref_clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    clkstop_pwrup #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
        .clk    (ref_clk),
        .rst    (rst),
        .pwr_ok (ctl_s.pwr_ok),
        .run_ok (run_ok)
    );

    clkstop_enables u_en (
        .ctl    (ctl_s),
        .run_ok (run_ok),
        .en_req (en_req)
    );

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_gate
            clkstop_gate u_gate (
                .src   (clk_src[g]),
                .rst   (rst),
                .en_in (en_req[g]),
                .gclk  (clk_out[g])
            );
        end
    endgenerate

    // Oscillators run whenever the synchronized request says powered.
    assign osc_en = ctl_s.pwr_ok;

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk
    import clkstop_pkg::*;
(
    input logic            rst,
    input logic [NGRP-1:0] clk_src,
    input logic            cpu_stop_n,
    input logic            pci_stop_n,
    input logic            pwr_dn_n,
    input logic [NGRP-1:0] clk_out,
    input logic            osc_en,
    input logic [NGRP-1:0] en_req,
    input logic            run_ok
);

    logic ref_clk;
    assign ref_clk = clk_src[G_PCIF];

    // R1: a power-down seen two reference edges ago keeps everything off
    p_pd_all_off_r1: assert property (@(posedge ref_clk) disable iff (rst)
        !$past(pwr_dn_n, 2) |-> (en_req == '0) && !osc_en);

    // R2: CPU-stop seen two edges ago blocks CPU and 66 MHz groups
    p_cpu_stop_r2: assert property (@(posedge ref_clk) disable iff (rst)
        !$past(cpu_stop_n, 2) |-> !en_req[G_CPU] && !en_req[G_M66]);

    // R3: PCI-stop blocks only the stoppable PCI group
    p_pci_stop_r3: assert property (@(posedge ref_clk) disable iff (rst)
        !$past(pci_stop_n, 2) |-> !en_req[G_PCI]);

    p_pcif_free_r3: assert property (@(posedge ref_clk) disable iff (rst)
        (run_ok && osc_en) |-> en_req[G_PCIF]);

    // R4: free groups follow power state only
    p_free_groups_r4: assert property (@(posedge ref_clk) disable iff (rst)
        (run_ok && osc_en) |->
        (en_req[G_CPUH] && en_req[G_APIC] && en_req[G_REF] && en_req[G_U48]));

    // R5: no run permission after a reference edge that saw power-down
    p_no_early_run_r5: assert property (@(posedge ref_clk) disable iff (rst)
        !osc_en |=> !run_ok);

    // R6: reset clears the delay and the oscillator enable
    p_reset_clears_r6: assert property (@(posedge ref_clk)
        rst |=> !run_ok && !osc_en);

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_chk
            // R6: after a falling edge in reset, the next high phase is quiet
            p_reset_quiet_r6: assert property (@(negedge clk_src[g])
                rst |=> !clk_out[g]);

            // R7: output was low during the preceding low phase of its source
            p_no_runt_r7: assert property (@(posedge clk_src[g]) disable iff (rst)
                !clk_out[g]);

            // R1: an output high phase only occurs while oscillators are on
            p_high_needs_power_r1: assert property (@(negedge clk_src[g]) disable iff (rst)
                clk_out[g] |-> osc_en || $past(osc_en));
        end
    endgenerate

endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
    .rst        (rst),
    .clk_src    (clk_src),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .pwr_dn_n   (pwr_dn_n),
    .clk_out    (clk_out),
    .osc_en     (osc_en),
    .en_req     (en_req),
    .run_ok     (run_ok)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
    import clkstop_pkg::*;

    localparam int K  = 6;      // short power-up delay for simulation
    localparam int NT = 3000;   // ticks of 2.5 ns; CPU source is the 200 MHz clock
    localparam int HALF [NGRP] = '{1, 2, 8, 3, 4, 4, 7, 5};

    logic            rst = 1'b1;
    logic [NGRP-1:0] clk_src = '0;
    logic            cpu_stop_n = 1'b1;
    logic            pci_stop_n = 1'b1;
    logic            pwr_dn_n = 1'b1;
    logic [NGRP-1:0] clk_out;
    logic            osc_en;

    int  errs = 0;
    int  checks = 0;
    bit  done = 0;

    // reference model state
    logic [2:0]      hq [$];    // synchronized history {pd, pci, cpu}; [1] is the settled value
    int              streak = 0;
    logic [NGRP-1:0] men = '0;
    logic [NGRP-1:0] prev_out = '0;
    logic [NGRP-1:0] prev_src = '0;

    clkstop_ctrl #(.PWRUP_CYC(K)) u0 (
        .rst        (rst),
        .clk_src    (clk_src),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .pwr_dn_n   (pwr_dn_n),
        .clk_out    (clk_out),
        .osc_en     (osc_en)
    );

    function automatic logic src_at(int g, int t);
        return ((t / HALF[g]) % 2) == 1;
    endfunction

    function automatic logic allow(int g, logic [2:0] d, int st);
        logic ok;
        ok = (st >= K) && d[2];
        if ((g == 0 || g == 3) && !d[0]) ok = 1'b0;
        if (g == 4 && !d[1]) ok = 1'b0;
        return ok;
    endfunction

    task automatic check(bit ok, string tag, string what, int t, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s tick %0d: actual=%0d expected=%0d", tag, what, t, act, exp);
        end
    endtask

    task automatic stimulus(int t);
        case (t)
            60:   rst = 1'b0;
            200:  cpu_stop_n = 1'b0;
            400:  cpu_stop_n = 1'b1;
            500:  pci_stop_n = 1'b0;
            700:  pci_stop_n = 1'b1;
            800:  begin cpu_stop_n = 1'b0; pci_stop_n = 1'b0; end
            1000: begin cpu_stop_n = 1'b1; pci_stop_n = 1'b1; end
            1100: pwr_dn_n = 1'b0;
            1400: pwr_dn_n = 1'b1;
            1600: cpu_stop_n = 1'b0;
            1603: cpu_stop_n = 1'b1;
            1700: pwr_dn_n = 1'b0;
            1720: pwr_dn_n = 1'b1;
            1740: pwr_dn_n = 1'b0;
            1745: pwr_dn_n = 1'b1;
            1900: rst = 1'b1;
            1940: rst = 1'b0;
            2200: pwr_dn_n = 1'b0;
            2210: cpu_stop_n = 1'b0;
            2300: pwr_dn_n = 1'b1;
            2500: cpu_stop_n = 1'b1;
            2600: pci_stop_n = 1'b0;
            2607: pci_stop_n = 1'b1;
            2650: pci_stop_n = 1'b0;
            2750: pci_stop_n = 1'b1;
            default: ;
        endcase
    endtask

    initial begin
        hq = '{3'b000, 3'b000};
        #1.25;
        for (int t = 1; t < NT; t++) begin
            logic [NGRP-1:0] nsrc;
            logic [2:0]      d2;
            for (int g = 0; g < NGRP; g++) nsrc[g] = src_at(g, t);
            d2 = hq[1];
            // falling edges use the state before any coincident reference edge
            for (int g = 0; g < NGRP; g++)
                if (clk_src[g] && !nsrc[g]) men[g] = rst ? 1'b0 : allow(g, d2, streak);
            if (!clk_src[5] && nsrc[5]) begin
                if (rst) begin
                    streak = 0;
                    hq = '{3'b000, 3'b000};
                end else begin
                    streak = d2[2] ? streak + 1 : 0;
                    hq.push_front({pwr_dn_n, pci_stop_n, cpu_stop_n});
                    void'(hq.pop_back());
                end
            end
            clk_src = nsrc;
            #0.5;
            if (t >= 30) begin
                string otag;
                if (rst) otag = "R6"; else otag = hq[1][2] ? "R5" : "R1";
                check(osc_en == hq[1][2], otag, "osc_en", t, osc_en, hq[1][2]);
                for (int g = 0; g < NGRP; g++) begin
                    string tag;
                    logic  ex;
                    ex = nsrc[g] & men[g];
                    if (rst)                tag = "R6";
                    else if (!hq[1][2])     tag = "R1";
                    else if (streak < K)    tag = "R5";
                    else if (g == 0 || g == 3) tag = "R2";
                    else if (g == 4 || g == 5) tag = "R3";
                    else                    tag = "R4";
                    check(clk_out[g] == ex, tag, $sformatf("clk_out[%0d]", g), t, clk_out[g], ex);
                    if (clk_out[g] && !prev_out[g])
                        check(nsrc[g] && !prev_src[g], "R7", $sformatf("rise of clk_out[%0d] without source rise", g),
                              t, 0, 1);
                    if (clk_out[g])
                        check(nsrc[g] == 1'b1, "R7", $sformatf("clk_out[%0d] high with source low", g), t, 0, 1);
                end
            end
            prev_out = clk_out;
            prev_src = nsrc;
            #0.75;
            stimulus(t);
            #1.25;
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(NT * 2.5 * 2 + 100);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule